// File: doc/BRIEF.md
# Ten-Bit Jitter Test Pattern Generator

This block sits in front of the serializer of a ten-bit physical interface and produces one 10-bit code group on every transmit clock. In normal operation it forwards the already-encoded transmit code groups. When diagnostics are switched on, it replaces that stream with a repeating jitter test pattern so that the receiver's clock recovery can be stressed with a known bit sequence.

A 3-bit selector picks the pattern. The choices are a word that software programs, four fixed repeating code groups (high frequency, mixed frequency, low frequency and square wave), and a rotating sequence of four words. Two selector values are reserved and fall back to normal data. Bit 9 of every code group is the first bit sent on the line, so each pattern below is written with its first line bit as the most significant bit. The output is registered. The stream runs at one word per clock and has no back-pressure: the serializer takes a word on every clock, so there is no valid or ready handshake, and the control inputs are plain levels.

Top module: `jpg_tbi_jitter_gen`

## Requirements
- R1: While `rst_n` is low, `tbi_out` is 0x000 and `pat_active` is 0.
- R2: When `jit_en` is 0, `tbi_out` equals the `txd_in` value sampled at the previous rising clock edge, and `pat_active` is 0.
- R3: Output is registered. `tbi_out` and `pat_active` reflect the inputs sampled at the previous edge. `pat_active` is 1 only if `jit_en` was 1 and `pat_sel` was 0 to 5 at that edge.
- R4: With `jit_en`=1 and `pat_sel`=000, `tbi_out` is the `user_word` sampled at the previous edge.
- R5: With `pat_sel`=001 (high frequency), `tbi_out` is 0x2AA (1010101010) on every clock.
- R6: With `pat_sel`=010 (mixed frequency), `tbi_out` alternates 0x3EB (1111101011) and 0x014 (0000010100), starting with 0x3EB.
- R7: With `pat_sel`=011 (low frequency), `tbi_out` is 0x3E0 (1111100000) on every clock.
- R8: With `pat_sel`=100 (complex), `tbi_out` steps through 0x17C, 0x0C9, 0x0E5, 0x2A3 and then wraps back to 0x17C.
- R9: With `pat_sel`=101 (square wave), `tbi_out` is 0x0F8 (0011111000) on every clock.
- R10: With `pat_sel`=110 or 111 and `jit_en`=1, `tbi_out` follows `txd_in` as in R2 and `pat_active` is 0.
- R11: The mixed and complex sequences restart at their first word (0x3EB and 0x17C) on the first enabled cycle after `jit_en` rises or after `pat_sel` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one code group per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| jit_en | input | 1 | 1 = transmit the test pattern, 0 = normal data |
| pat_sel | input | 3 | Pattern selector |
| user_word | input | 10 | Programmable custom code group |
| txd_in | input | 10 | Normal encoded transmit code group |
| tbi_out | output | 10 | Code group to the serializer, bit 9 sent first |
| pat_active | output | 1 | A test pattern is being driven |

## Verification
The bound checker tests, on every cycle, the one-clock relationship between the inputs and the outputs. This covers the pass-through of normal data, the fixed words, the custom word, the fallback for reserved selectors and the meaning of the active flag. It also checks that the mixed and complex sequences advance and restart correctly once at least two cycles have passed since reset. Only the bench scenarios can show the exact order of whole sequences across enable toggles, selector changes and wrap-around, and the output value while reset is held.

// File: rtl/jpg_pkg.sv
package jpg_pkg;

  localparam int CG_W   = 10;
  localparam int SEL_W  = 3;
  localparam int SEQ_LEN = 4;
  localparam int PH_W   = $clog2(SEQ_LEN);

  typedef logic [CG_W-1:0] cg_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_USER    = 3'd0,
    SEL_HIFREQ  = 3'd1,
    SEL_MIXED   = 3'd2,
    SEL_LOFREQ  = 3'd3,
    SEL_COMPLEX = 3'd4,
    SEL_SQUARE  = 3'd5,
    SEL_RSV_A   = 3'd6,
    SEL_RSV_B   = 3'd7
  } jit_sel_e;

  localparam cg_t CG_HIFREQ  = 10'h2AA;
  localparam cg_t CG_MIX_POS = 10'h3EB;
  localparam cg_t CG_MIX_NEG = 10'h014;
  localparam cg_t CG_LOFREQ  = 10'h3E0;
  localparam cg_t CG_SQUARE  = 10'h0F8;

  function automatic cg_t complex_word(input logic [PH_W-1:0] idx);
    case (idx)
      2'd0:    complex_word = 10'h17C;
      2'd1:    complex_word = 10'h0C9;
      2'd2:    complex_word = 10'h0E5;
      default: complex_word = 10'h2A3;
    endcase
  endfunction

  function automatic logic sel_reserved(input logic [SEL_W-1:0] s);
    sel_reserved = (s == SEL_RSV_A) || (s == SEL_RSV_B);
  endfunction

  function automatic logic sel_sequenced(input logic [SEL_W-1:0] s);
    sel_sequenced = (s == SEL_MIXED) || (s == SEL_COMPLEX);
  endfunction

endpackage

// File: rtl/jpg_phase.sv
module jpg_phase
  import jpg_pkg::*;
#(
  parameter int SEQ = SEQ_LEN,
  localparam int PW = $clog2(SEQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [PW-1:0]    idx
);

  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic [PW-1:0]    ph_q;
  logic             restart;
  logic [PW-1:0]    idx_nxt;

  always_comb begin
    restart = en && (!en_q || (sel != sel_q));
    idx     = restart ? '0 : ph_q;
    if (idx == PW'(SEQ - 1)) idx_nxt = '0;
    else                     idx_nxt = idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
      ph_q  <= '0;
    end else begin
      en_q  <= en;
      sel_q <= sel;
      ph_q  <= en ? idx_nxt : '0;
    end
  end

endmodule

// File: rtl/jpg_pattern.sv
module jpg_pattern
  import jpg_pkg::*;
#(
  parameter int PW = PH_W
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic [PW-1:0]    idx,
  input  cg_t              user_word,
  input  cg_t              txd,
  output cg_t              word,
  output logic             active
);

  cg_t pat;

  always_comb begin
    unique case (jit_sel_e'(sel))
      SEL_USER:    pat = user_word;
      SEL_HIFREQ:  pat = CG_HIFREQ;
      SEL_MIXED:   pat = idx[0] ? CG_MIX_NEG : CG_MIX_POS;
      SEL_LOFREQ:  pat = CG_LOFREQ;
      SEL_COMPLEX: pat = complex_word(idx[1:0]);
      SEL_SQUARE:  pat = CG_SQUARE;
      default:     pat = txd;
    endcase
    active = en && !sel_reserved(sel);
    word   = active ? pat : txd;
  end

endmodule

// File: rtl/jpg_out.sv
module jpg_out
  import jpg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cg_t  word_d,
  input  logic act_d,
  output cg_t  word_q,
  output logic act_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      act_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      act_q  <= act_d;
    end
  end

endmodule

// File: rtl/jpg_tbi_jitter_gen.sv
module jpg_tbi_jitter_gen
  import jpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             jit_en,
  input  logic [SEL_W-1:0] pat_sel,
  input  logic [CG_W-1:0]  user_word,
  input  logic [CG_W-1:0]  txd_in,
  output logic [CG_W-1:0]  tbi_out,
  output logic             pat_active
);

  logic [PH_W-1:0] seq_idx;
  cg_t             nxt_word;
  logic            nxt_act;

  jpg_phase #(.SEQ(SEQ_LEN)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (jit_en),
    .sel   (pat_sel),
    .idx   (seq_idx)
  );

  jpg_pattern #(.PW(PH_W)) u_pattern (
    .en        (jit_en),
    .sel       (pat_sel),
    .idx       (seq_idx),
    .user_word (user_word),
    .txd       (txd_in),
    .word      (nxt_word),
    .active    (nxt_act)
  );

  jpg_out u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .word_d (nxt_word),
    .act_d  (nxt_act),
    .word_q (tbi_out),
    .act_q  (pat_active)
  );

endmodule

// File: rtl/jpg_chk.sv
module jpg_chk
  import jpg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             jit_en,
  input logic [SEL_W-1:0] pat_sel,
  input logic [CG_W-1:0]  user_word,
  input logic [CG_W-1:0]  txd_in,
  input logic [CG_W-1:0]  tbi_out,
  input logic             pat_active
);

  logic [1:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               up_cnt <= 2'd0;
    else if (up_cnt != 2'd2)  up_cnt <= up_cnt + 2'd1;
  end

  function automatic logic [CG_W-1:0] cx_next(input logic [CG_W-1:0] w);
    case (w)
      10'h17C: cx_next = 10'h0C9;
      10'h0C9: cx_next = 10'h0E5;
      10'h0E5: cx_next = 10'h2A3;
      default: cx_next = 10'h17C;
    endcase
  endfunction

  AST_PASS_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt != 0 && !$past(jit_en)) |-> (tbi_out == $past(txd_in) && !pat_active)); // R2
  AST_ACTIVE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt != 0) |-> (pat_active == ($past(jit_en) && $past(pat_sel) <= 3'd5))); // R3
  AST_USER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt != 0 && $past(jit_en) && $past(pat_sel) == 3'd0) |-> (tbi_out == $past(user_word))); // R4
  AST_HIFREQ: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt != 0 && $past(jit_en) && $past(pat_sel) == 3'd1) |-> (tbi_out == 10'h2AA)); // R5
  AST_MIXED_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == 2 && $past(jit_en && pat_sel == 3'd2) && $past(jit_en && pat_sel == 3'd2, 2))
    |-> (tbi_out == (($past(tbi_out) == 10'h3EB) ? 10'h014 : 10'h3EB))); // R6
  AST_LOFREQ: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt != 0 && $past(jit_en) && $past(pat_sel) == 3'd3) |-> (tbi_out == 10'h3E0)); // R7
  AST_COMPLEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == 2 && $past(jit_en && pat_sel == 3'd4) && $past(jit_en && pat_sel == 3'd4, 2))
    |-> (tbi_out == cx_next($past(tbi_out)))); // R8
  AST_SQUARE: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt != 0 && $past(jit_en) && $past(pat_sel) == 3'd5) |-> (tbi_out == 10'h0F8)); // R9
  AST_RESERVED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt != 0 && $past(jit_en) && $past(pat_sel) >= 3'd6) |-> (tbi_out == $past(txd_in) && !pat_active)); // R10
  AST_MIXED_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == 2 && $past(jit_en && pat_sel == 3'd2) && !$past(jit_en && pat_sel == 3'd2, 2))
    |-> (tbi_out == 10'h3EB)); // R11
  AST_COMPLEX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == 2 && $past(jit_en && pat_sel == 3'd4) && !$past(jit_en && pat_sel == 3'd4, 2))
    |-> (tbi_out == 10'h17C)); // R11

endmodule

bind jpg_tbi_jitter_gen jpg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .jit_en     (jit_en),
  .pat_sel    (pat_sel),
  .user_word  (user_word),
  .txd_in     (txd_in),
  .tbi_out    (tbi_out),
  .pat_active (pat_active)
);

// File: tb/jpg_tbi_jitter_gen_tb.sv
`timescale 1ns/1ps
module jpg_tbi_jitter_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       jit_en = 1'b0;
  logic [2:0] pat_sel = 3'd0;
  logic [9:0] user_word = 10'h000;
  logic [9:0] txd_in = 10'h000;
  logic [9:0] tbi_out;
  logic       pat_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  jpg_tbi_jitter_gen u_dut (
    .clk(clk), .rst_n(rst_n), .jit_en(jit_en), .pat_sel(pat_sel),
    .user_word(user_word), .txd_in(txd_in),
    .tbi_out(tbi_out), .pat_active(pat_active)
  );

  typedef struct {
    logic [9:0] w;
    logic       a;
    string      tag;
  } exp_t;

  exp_t sb[$];

  // reference state for the sequenced patterns (R11)
  logic       m_en = 1'b0;
  logic [2:0] m_sel = 3'd0;
  int         m_ph = 0;

  function automatic logic [9:0] cx(input int i);
    case (i)
      0: return 10'h17C;
      1: return 10'h0C9;
      2: return 10'h0E5;
      default: return 10'h2A3;
    endcase
  endfunction

  task automatic step(input logic en, input logic [2:0] sel, input logic [9:0] uw,
                      input logic [9:0] txd, input string tag);
    exp_t e;
    int   idx;
    bit   rs;
    @(negedge clk);
    jit_en = en; pat_sel = sel; user_word = uw; txd_in = txd;
    rs  = en && (!m_en || sel != m_sel);
    idx = rs ? 0 : m_ph;
    m_ph  = en ? (idx + 1) % 4 : 0;
    m_en  = en;
    m_sel = sel;
    e.tag = tag;
    e.a   = en && (sel <= 3'd5);
    if (!e.a) e.w = txd;
    else case (sel)
      3'd0: e.w = uw;
      3'd1: e.w = 10'h2AA;
      3'd2: e.w = (idx % 2 == 0) ? 10'h3EB : 10'h014;
      3'd3: e.w = 10'h3E0;
      3'd4: e.w = cx(idx);
      default: e.w = 10'h0F8;
    endcase
    sb.push_back(e);
  endtask

  // monitor: compare each registered result shortly after the capturing edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (tbi_out !== e.w || pat_active !== e.a) begin
        errors++;
        $display("FAIL %s: got out=%h act=%b, expected out=%h act=%b",
                 e.tag, tbi_out, pat_active, e.w, e.a);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got running, expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (tbi_out !== 10'h000 || pat_active !== 1'b0) begin
      errors++;
      $display("FAIL R1: got out=%h act=%b, expected out=000 act=0", tbi_out, pat_active);
    end
    rst_n = 1'b1;

    // R2 / R3 normal pass-through
    step(0, 3'd0, 10'h155, 10'h1A7, "R2");
    step(0, 3'd4, 10'h155, 10'h2C3, "R2");
    step(0, 3'd2, 10'h000, 10'h3FF, "R3");
    // R4 custom word
    step(1, 3'd0, 10'h2C5, 10'h111, "R4");
    step(1, 3'd0, 10'h13A, 10'h111, "R4");
    // R5 high frequency
    for (int i = 0; i < 3; i++) step(1, 3'd1, 10'h0, 10'h0AB, "R5");
    // R6 mixed frequency
    for (int i = 0; i < 5; i++) step(1, 3'd2, 10'h0, 10'h0, "R6");
    // R7 low frequency
    for (int i = 0; i < 3; i++) step(1, 3'd3, 10'h0, 10'h0, "R7");
    // R8 complex with wrap
    for (int i = 0; i < 6; i++) step(1, 3'd4, 10'h0, 10'h0, "R8");
    // R9 square wave
    for (int i = 0; i < 3; i++) step(1, 3'd5, 10'h0, 10'h0, "R9");
    // R10 reserved selectors
    step(1, 3'd6, 10'h3FF, 10'h0C3, "R10");
    step(1, 3'd7, 10'h3FF, 10'h21E, "R10");
    // R11 restart on selector change and enable rise
    step(1, 3'd4, 10'h0, 10'h0, "R11");
    step(1, 3'd4, 10'h0, 10'h0, "R11");
    step(1, 3'd2, 10'h0, 10'h0, "R11");
    step(1, 3'd2, 10'h0, 10'h0, "R11");
    step(1, 3'd4, 10'h0, 10'h0, "R11");
    step(1, 3'd4, 10'h0, 10'h0, "R11");
    step(0, 3'd4, 10'h0, 10'h099, "R11");
    step(1, 3'd4, 10'h0, 10'h0, "R11");
    step(1, 3'd2, 10'h0, 10'h0, "R11");
    step(0, 3'd2, 10'h0, 10'h0, "R2");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule